// File: doc/BRIEF.md
# Query Deadlock Detector and Event Status Core

This block keeps the event status state of a message-based instrument interface and detects a deadlock on the query path. It watches two flags from neighbouring logic: one says a response is waiting to be sent, the other says the input command queue is full. If both are raised together, neither side can make progress. The block then records a query error in its event register and loads error code 2 into a query error code register. It also raises a one-cycle clear to the output queue and a one-cycle strobe that tells the parser to carry on with the next program message unit.

The event register is sticky. Event pulses from other parts of the device are ORed into it every cycle. A read returns its contents and clears it in the same access. A mask register, written by the host, selects which event bits feed the summary bit. That summary bit is bit 5 of the status byte that the neighbouring status logic builds. The code register is also cleared on read and reads as 0 when no error is pending.

Top module: `qstat_core`

## Requirements
- R1: When `resp_waiting` and `inq_full` are both 1 in a cycle, and were not both 1 in the previous cycle (or that cycle was under reset), `oq_clear` and `parse_resume` are 1 for exactly one cycle, after the next rising edge.
- R2: A deadlock event sets bit 2 (query error) of the event register.
- R3: A deadlock event loads the value 2 into the query error code register.
- R4: While the deadlock condition persists, no further deadlock event occurs. A new event needs the condition to drop and then return.
- R5: Each bit of `event_in` that is 1 in a cycle sets the same bit of the event register. The bit stays set until the register is read or reset.
- R6: When `esr_rd` is 1, `esr_rdata` shows the event register contents from that cycle after the next edge, and the register is cleared. `esr_rdata` holds its value until the next read.
- R7: An event that arrives in the same cycle as an event register read is not returned by that read. It remains set in the register after the clear.
- R8: `esb` is 1 exactly when some event register bit and the matching mask bit are both 1. It follows any change of either register on the same edge.
- R9: When `ese_wr_en` is 1, the mask register takes `ese_wr_data` on the next edge. It can be read on `ese_rdata`.
- R10: When `qe_rd` is 1, `qe_rdata` shows the code register from that cycle after the next edge, and the code register is cleared. With no error pending, the read returns 0. A deadlock event in the same cycle as the read is kept.
- R11: Synchronous active-high reset clears every register and output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resp_waiting | input | 1 | Response formatter has a response waiting |
| inq_full | input | 1 | Input command queue is full |
| event_in | input | 8 | Event pulses to OR into the event register |
| ese_wr_en | input | 1 | Mask register write strobe |
| ese_wr_data | input | 8 | Mask register write value |
| esr_rd | input | 1 | Event register read-and-clear strobe |
| qe_rd | input | 1 | Query error code read-and-clear strobe |
| esr_rdata | output | 8 | Value captured by the last event register read |
| ese_rdata | output | 8 | Current mask register |
| qe_rdata | output | 8 | Value captured by the last code register read |
| esb | output | 1 | Event summary bit (status byte bit 5) |
| oq_clear | output | 1 | One-cycle output queue clear |
| parse_resume | output | 1 | One-cycle strobe telling the parser to resume |

## Verification
Every output of this block is a register. A stimulus applied in one cycle therefore shows at the ports exactly one edge later: the deadlock pulses, the captured read values, the mask and the summary bit that follows a write or an event. The bench drives each stimulus vector on a falling edge and compares all outputs at the next falling edge. That is one rising edge later, which is the cycle in which they are due.

The table puts a read in the same cycle as a new event or a new deadlock, so that the one-edge boundary between the old and the new contents is observed directly.

// File: rtl/qstat_pkg.sv
package qstat_pkg;
  localparam int unsigned STAT_W        = 8;
  localparam int unsigned CODE_W        = 8;
  localparam int unsigned QERR_POS      = 2;
  localparam int unsigned ESB_POS       = 5;
  localparam int unsigned DEADLOCK_CODE = 2;
endpackage

// File: rtl/qstat_deadlock.sv
module qstat_deadlock (
  input  logic clk,
  input  logic rst,
  input  logic resp_waiting,
  input  logic inq_full,
  output logic dl_event,
  output logic oq_clear,
  output logic parse_resume
);
  logic dl_now;
  logic dl_prev;

  assign dl_now   = resp_waiting & inq_full;
  assign dl_event = dl_now & ~dl_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      dl_prev      <= 1'b0;
      oq_clear     <= 1'b0;
      parse_resume <= 1'b0;
    end else begin
      dl_prev      <= dl_now;
      oq_clear     <= dl_event;
      parse_resume <= dl_event;
    end
  end
endmodule

// File: rtl/qstat_sticky_reg.sv
module qstat_sticky_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         rd_clr,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt,
  output logic [W-1:0] rd_data
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt[i] = set_vec[i] | (q[i] & ~rd_clr);
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_clr) rd_data <= q;
  end
endmodule

// File: rtl/qstat_code_reg.sv
module qstat_code_reg #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned CODE   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              rd,
  output logic [CODE_W-1:0] rd_data
);
  localparam logic [CODE_W-1:0] CODE_V = CODE_W'(CODE);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      rd_data <= '0;
    end else begin
      if (load)    code_q <= CODE_V;
      else if (rd) code_q <= '0;
      if (rd) rd_data <= code_q;
    end
  end
endmodule

// File: rtl/qstat_core.sv
module qstat_core
  import qstat_pkg::*;
#(
  parameter int unsigned SW       = STAT_W,
  parameter int unsigned CW       = CODE_W,
  parameter int unsigned QE_POS   = QERR_POS,
  parameter int unsigned DL_CODE  = DEADLOCK_CODE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          resp_waiting,
  input  logic          inq_full,
  input  logic [SW-1:0] event_in,
  input  logic          ese_wr_en,
  input  logic [SW-1:0] ese_wr_data,
  input  logic          esr_rd,
  input  logic          qe_rd,
  output logic [SW-1:0] esr_rdata,
  output logic [SW-1:0] ese_rdata,
  output logic [CW-1:0] qe_rdata,
  output logic          esb,
  output logic          oq_clear,
  output logic          parse_resume
);
  logic          dl_event;
  logic [SW-1:0] ev_vec;
  logic [SW-1:0] esr_q;
  logic [SW-1:0] esr_nxt;
  logic [SW-1:0] ese_q;
  logic [SW-1:0] ese_nxt;

  qstat_deadlock i_dl (
    .clk          (clk),
    .rst          (rst),
    .resp_waiting (resp_waiting),
    .inq_full     (inq_full),
    .dl_event     (dl_event),
    .oq_clear     (oq_clear),
    .parse_resume (parse_resume)
  );

  always_comb begin
    ev_vec         = event_in;
    ev_vec[QE_POS] = event_in[QE_POS] | dl_event;
  end

  qstat_sticky_reg #(.W(SW)) i_esr (
    .clk     (clk),
    .rst     (rst),
    .set_vec (ev_vec),
    .rd_clr  (esr_rd),
    .q       (esr_q),
    .nxt     (esr_nxt),
    .rd_data (esr_rdata)
  );

  qstat_code_reg #(.CODE_W(CW), .CODE(DL_CODE)) i_qe (
    .clk     (clk),
    .rst     (rst),
    .load    (dl_event),
    .rd      (qe_rd),
    .rd_data (qe_rdata)
  );

  assign ese_nxt   = ese_wr_en ? ese_wr_data : ese_q;
  assign ese_rdata = ese_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ese_q <= '0;
      esb   <= 1'b0;
    end else begin
      ese_q <= ese_nxt;
      esb   <= |(esr_nxt & ese_nxt);
    end
  end

  logic unused_esr;
  assign unused_esr = ^esr_q;
endmodule

// File: rtl/qstat_core_checks.sv
module qstat_core_checks #(
  parameter int unsigned SW = 8,
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          resp_waiting,
  input logic          inq_full,
  input logic          ese_wr_en,
  input logic [SW-1:0] ese_wr_data,
  input logic          esr_rd,
  input logic          qe_rd,
  input logic [SW-1:0] esr_rdata,
  input logic [SW-1:0] ese_rdata,
  input logic [CW-1:0] qe_rdata,
  input logic          esb,
  input logic          oq_clear,
  input logic          parse_resume
);
  assert_deadlock_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    (resp_waiting && inq_full && !$past(resp_waiting && inq_full)) |=> (oq_clear && parse_resume));

  assert_clear_has_cause_R1: assert property (@(posedge clk) disable iff (rst)
    oq_clear |-> $past(resp_waiting && inq_full));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    oq_clear |=> !oq_clear);

  assert_esr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !esr_rd |=> $stable(esr_rdata));

  assert_mask_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (ese_rdata == '0) |-> !esb);

  assert_mask_write_R9: assert property (@(posedge clk) disable iff (rst)
    ese_wr_en |=> (ese_rdata == $past(ese_wr_data)));

  assert_code_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !qe_rd |=> $stable(qe_rdata));
endmodule

bind qstat_core qstat_core_checks #(.SW(SW), .CW(CW)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .resp_waiting (resp_waiting),
  .inq_full     (inq_full),
  .ese_wr_en    (ese_wr_en),
  .ese_wr_data  (ese_wr_data),
  .esr_rd       (esr_rd),
  .qe_rd        (qe_rd),
  .esr_rdata    (esr_rdata),
  .ese_rdata    (ese_rdata),
  .qe_rdata     (qe_rdata),
  .esb          (esb),
  .oq_clear     (oq_clear),
  .parse_resume (parse_resume)
);

// File: tb/test_qstat_core.sv
module test_qstat_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       resp_waiting = 1'b0, inq_full = 1'b0;
  logic [7:0] event_in = '0;
  logic       ese_wr_en = 1'b0;
  logic [7:0] ese_wr_data = '0;
  logic       esr_rd = 1'b0, qe_rd = 1'b0;
  logic [7:0] esr_rdata, ese_rdata, qe_rdata;
  logic       esb, oq_clear, parse_resume;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  qstat_core i_qstat_core (
    .clk(clk), .rst(rst), .resp_waiting(resp_waiting), .inq_full(inq_full),
    .event_in(event_in), .ese_wr_en(ese_wr_en), .ese_wr_data(ese_wr_data),
    .esr_rd(esr_rd), .qe_rd(qe_rd), .esr_rdata(esr_rdata), .ese_rdata(ese_rdata),
    .qe_rdata(qe_rdata), .esb(esb), .oq_clear(oq_clear), .parse_resume(parse_resume)
  );

  typedef struct packed {
    logic       rw; logic full; logic [7:0] ev; logic we; logic [7:0] wd;
    logic       er; logic qr;
    logic [7:0] x_esr; logic [7:0] x_qe; logic [7:0] x_ese; logic x_esb; logic x_clr;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    // rw  full  ev     we    wd     er    qr    esr    qe     ese    esb   clr
    '{1'b0,1'b0,8'h00,1'b1,8'h04,1'b0,1'b0,8'h00,8'h00,8'h04,1'b0,1'b0}, // R9 mask write
    '{1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,1'b0,8'h00,8'h00,8'h04,1'b0,1'b0}, // R1 one flag only
    '{1'b1,1'b1,8'h00,1'b0,8'h00,1'b0,1'b0,8'h00,8'h00,8'h04,1'b1,1'b1}, // R1 R2 R3 deadlock
    '{1'b1,1'b1,8'h00,1'b0,8'h00,1'b0,1'b0,8'h00,8'h00,8'h04,1'b1,1'b0}, // R4 persists
    '{1'b1,1'b1,8'h00,1'b0,8'h00,1'b1,1'b1,8'h04,8'h02,8'h04,1'b0,1'b0}, // R2 R3 R6 R10 reads
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,1'b0,8'h04,8'h02,8'h04,1'b0,1'b0}, // R6 hold
    '{1'b0,1'b0,8'h81,1'b0,8'h00,1'b0,1'b0,8'h04,8'h02,8'h04,1'b0,1'b0}, // R5 events, masked
    '{1'b0,1'b0,8'h00,1'b1,8'h01,1'b0,1'b0,8'h04,8'h02,8'h01,1'b1,1'b0}, // R8 R9 mask change
    '{1'b0,1'b0,8'h20,1'b0,8'h00,1'b1,1'b0,8'h81,8'h02,8'h01,1'b0,1'b0}, // R7 event with read
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,1'b0,8'h20,8'h02,8'h01,1'b0,1'b0}, // R7 kept event
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,1'b1,8'h20,8'h00,8'h01,1'b0,1'b0}, // R10 empty read 0
    '{1'b1,1'b1,8'h00,1'b0,8'h00,1'b1,1'b1,8'h00,8'h00,8'h01,1'b0,1'b1}, // R7 R10 deadlock with reads
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,1'b1,8'h00,8'h02,8'h01,1'b0,1'b0}, // R10 kept code
    '{1'b1,1'b1,8'h00,1'b0,8'h00,1'b0,1'b0,8'h00,8'h02,8'h01,1'b0,1'b1}, // R4 new event after drop
    '{1'b0,1'b0,8'h00,1'b1,8'hFF,1'b0,1'b0,8'h00,8'h02,8'hFF,1'b1,1'b0}, // R8 full mask
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,1'b1,8'h04,8'h02,8'hFF,1'b0,1'b0}  // R2 R6 R10 final reads
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input vec_t v);
    resp_waiting = v.rw; inq_full = v.full; event_in = v.ev;
    ese_wr_en = v.we; ese_wr_data = v.wd; esr_rd = v.er; qe_rd = v.qr;
  endtask

  task automatic idle();
    resp_waiting = 1'b0; inq_full = 1'b0; event_in = '0;
    ese_wr_en = 1'b0; ese_wr_data = '0; esr_rd = 1'b0; qe_rd = 1'b0;
  endtask

  task automatic chk_zero(input string tag);
    chk({tag, " esr_rdata"}, esr_rdata, 8'h00);
    chk({tag, " ese_rdata"}, ese_rdata, 8'h00);
    chk({tag, " qe_rdata"},  qe_rdata,  8'h00);
    chk({tag, " esb"},          {7'd0, esb},          8'h00);
    chk({tag, " oq_clear"},     {7'd0, oq_clear},     8'h00);
    chk({tag, " parse_resume"}, {7'd0, parse_resume}, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_zero("R11 reset");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      chk("R6 esr_rdata", esr_rdata, VEC[i].x_esr);
      chk("R10 qe_rdata", qe_rdata, VEC[i].x_qe);
      chk("R9 ese_rdata", ese_rdata, VEC[i].x_ese);
      chk("R8 esb", {7'd0, esb}, {7'd0, VEC[i].x_esb});
      chk("R1 oq_clear", {7'd0, oq_clear}, {7'd0, VEC[i].x_clr});
      chk("R1 parse_resume", {7'd0, parse_resume}, {7'd0, VEC[i].x_clr});
    end

    // Directed: an event bit set, then a reset held while the deadlock is present
    idle(); event_in = 8'h10;
    @(negedge clk);
    idle(); resp_waiting = 1'b1; inq_full = 1'b1; rst = 1'b1;
    repeat (2) @(negedge clk);
    chk_zero("R11 mid-run reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1 deadlock present at reset release", {7'd0, oq_clear}, 8'h01);
    esr_rd = 1'b1; qe_rd = 1'b1;
    @(negedge clk);
    chk("R4 no repeat pulse", {7'd0, oq_clear}, 8'h00);
    chk("R11 R2 event reg after reset", esr_rdata, 8'h04);
    chk("R3 code after reset release", qe_rdata, 8'h02);
    idle();
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule